// File: doc/BRIEF.md
# Card Clock Divider with Staged Update Handshake

This block derives the card bus clock from the module clock. Software programs a divider value and an enable bit into a configuration register. That register only stages the settings. The running divider keeps its old settings until software writes the command register with an update-only request. The block then loads the staged settings into the live divider at a safe point of the card clock waveform. It clears the request's start bit and raises two sticky interrupt flags.

The usual sequence is three steps, each followed by an update request: switch the clock off, change the divider, and switch it back on. A request can ask to wait until a data transfer in progress, reported on an input, has ended. The block never sends card commands. The command register is used here only as the trigger for a clock update.

Top module: `cardclk_ctl`

## Requirements
- R1: After reset every register reads 0 and `card_clk` is low.
- R2: Writing address 0 (divider in bits 7:0, enable in bit 16) changes only what address 0 reads back. The live settings at address 3 (same layout, read-only) and the `card_clk` waveform stay unchanged until an update is applied.
- R3: A write to address 1 with bit 31 (start) and bit 21 (update-only) both set requests an update. Bit 31 then reads 1 until the staged settings are applied, and 0 after that. A write to address 1 that lacks either bit, or that arrives while a request is pending, is ignored.
- R4: If the request also sets bit 13 (wait), the update is held back while `xfer_busy` is high and is applied after it drops. Without bit 13, `xfer_busy` has no effect.
- R5: Applying an update sets bit 0 (clock updated) and bit 1 (command done) at address 2. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: With enable set and divider D of 1 or more, `card_clk` stays high for D module clock cycles and low for D cycles, so its frequency is the module clock over 2*D.
- R7: With enable set and divider 0, `card_clk` follows the module clock.
- R8: With enable clear, `card_clk` stays low.
- R9: New settings take over only at the end of a complete low phase, or at once when the clock is off or undivided. Every high pulse therefore lasts the full old or the full new half period, with no runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xfer_busy | input | 1 | High while a previous data transfer is active |
| card_clk | output | 1 | Card bus clock |

## Verification
The bench changes the divider while the card clock is running, in both directions. It checks that every high pulse it sees has the full old or the full new length. A design that swaps settings in mid-phase would show up as a runt pulse of some other length. The bench holds `xfer_busy` high with the wait flag set and expects the start bit to stay at 1. It also sends a second request while the first is pending, which must be ignored: a design that lets it through would either apply the update early or overwrite the wait flag. Random divider and enable settings are checked against expected pulse lengths, which also covers the pass-through case of divider 0 and the clock held low when disabled. The interrupt bits are cleared one at a time to catch a design that clears the whole register at once.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned REG_AW   = 2;
  localparam int unsigned REG_DW   = 32;

  localparam logic [REG_AW-1:0] A_CFG = 2'd0;
  localparam logic [REG_AW-1:0] A_CMD = 2'd1;
  localparam logic [REG_AW-1:0] A_IRQ = 2'd2;
  localparam logic [REG_AW-1:0] A_ACT = 2'd3;

  localparam int unsigned CFG_EN_BIT   = 16;
  localparam int unsigned CMD_GO_BIT   = 31;
  localparam int unsigned CMD_ONLY_BIT = 21;
  localparam int unsigned CMD_HOLD_BIT = 13;
  localparam int unsigned IRQ_W        = 2;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
  } clk_set_t;
endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
  import cardclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              apply,
  input  clk_set_t          live,
  output clk_set_t          staged,
  output logic              pend,
  output logic              hold,
  output logic [IRQ_W-1:0]  irq,
  output logic [REG_DW-1:0] rdata
);
  clk_set_t         stg_q, stg_n;
  logic             pend_q, pend_n;
  logic             hold_q, hold_n;
  logic             only_q, only_n;
  logic [IRQ_W-1:0] irq_q, irq_n;
  logic             go_w;
  logic [IRQ_W-1:0] clr_w;

  always_comb begin
    go_w   = wr && (addr == A_CMD) && wdata[CMD_GO_BIT] && wdata[CMD_ONLY_BIT] && !pend_q;
    clr_w  = (wr && (addr == A_IRQ)) ? wdata[IRQ_W-1:0] : '0;
    stg_n  = stg_q;
    if (wr && (addr == A_CFG)) begin
      stg_n.div = wdata[DIV_W-1:0];
      stg_n.en  = wdata[CFG_EN_BIT];
    end
    pend_n = go_w ? 1'b1 : (apply ? 1'b0 : pend_q);
    hold_n = go_w ? wdata[CMD_HOLD_BIT] : hold_q;
    only_n = go_w ? 1'b1 : only_q;
    irq_n  = (irq_q & ~clr_w) | {IRQ_W{apply}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
      only_q <= 1'b0;
      irq_q  <= '0;
    end else begin
      stg_q  <= stg_n;
      pend_q <= pend_n;
      hold_q <= hold_n;
      only_q <= only_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG: begin
        rdata[DIV_W-1:0]  = stg_q.div;
        rdata[CFG_EN_BIT] = stg_q.en;
      end
      A_CMD: begin
        rdata[CMD_GO_BIT]   = pend_q;
        rdata[CMD_ONLY_BIT] = only_q;
        rdata[CMD_HOLD_BIT] = hold_q;
      end
      A_IRQ: rdata[IRQ_W-1:0] = irq_q;
      default: begin
        rdata[DIV_W-1:0]  = live.div;
        rdata[CFG_EN_BIT] = live.en;
      end
    endcase
  end

  assign staged = stg_q;
  assign pend   = pend_q;
  assign hold   = hold_q;
  assign irq    = irq_q;
endmodule

// File: rtl/cardclk_update.sv
module cardclk_update
  import cardclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend,
  input  logic     hold,
  input  logic     busy,
  input  logic     safe_pt,
  input  clk_set_t staged,
  output logic     apply,
  output clk_set_t live
);
  clk_set_t live_q, live_n;
  logic     gate_ok;

  always_comb begin
    gate_ok = !hold || !busy;
    apply   = pend && gate_ok && safe_pt;
    live_n  = apply ? staged : live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_n;
  end

  assign live = live_q;
endmodule

// File: rtl/cardclk_divgen.sv
module cardclk_divgen
  import cardclk_pkg::*;
#(
  parameter bit ZERO_BYPASS = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_set_t live,
  input  logic     apply,
  output logic     safe_pt,
  output logic     div_q,
  output logic     card_clk
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             tog_q, tog_n;
  logic             run_div, end_half, byp_req;

  always_comb begin
    run_div  = live.en && (live.div != '0);
    end_half = (cnt_q == live.div - 1'b1);
    byp_req  = live.en && (live.div == '0);
    safe_pt  = !run_div || (!tog_q && end_half);
    cnt_n    = cnt_q;
    tog_n    = tog_q;
    if (apply || !run_div) begin
      cnt_n = '0;
      tog_n = 1'b0;
    end else if (end_half) begin
      cnt_n = '0;
      tog_n = !tog_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      tog_q <= tog_n;
    end
  end

  generate
    if (ZERO_BYPASS) begin : g_byp
      logic byp_g;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) byp_g <= 1'b0;
        else        byp_g <= byp_req;
      end
      assign card_clk = (clk & byp_g) | tog_q;
    end else begin : g_nobyp
      assign card_clk = tog_q;
    end
  endgenerate

  assign div_q = tog_q;
endmodule

// File: rtl/cardclk_ctl.sv
module cardclk_ctl
  import cardclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              xfer_busy,
  output logic              card_clk
);
  logic [1:0]       rst_sync;
  logic             rst_sn;
  clk_set_t         staged, live;
  logic             pend, hold, apply, safe_pt, div_q;
  logic [IRQ_W-1:0] irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  cardclk_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .apply(apply), .live(live), .staged(staged), .pend(pend), .hold(hold),
    .irq(irq), .rdata(reg_rdata)
  );

  cardclk_update u_upd (
    .clk(clk), .rst_n(rst_sn), .pend(pend), .hold(hold), .busy(xfer_busy),
    .safe_pt(safe_pt), .staged(staged), .apply(apply), .live(live)
  );

  cardclk_divgen #(.ZERO_BYPASS(1'b1)) u_div (
    .clk(clk), .rst_n(rst_sn), .live(live), .apply(apply),
    .safe_pt(safe_pt), .div_q(div_q), .card_clk(card_clk)
  );
endmodule

// File: rtl/cardclk_ctl_chk.sv
module cardclk_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       apply,
  input logic       pend,
  input logic       hold,
  input logic       busy,
  input logic       div_q,
  input logic       live_en,
  input logic [7:0] live_div,
  input logic [1:0] irq
);
  p_wait_honored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> !(hold && busy));
  p_low_phase_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> !div_q);
  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !live_en |-> !div_q);
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !pend);
  p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> ($stable(live_div) && $stable(live_en)));
  p_irq_on_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(apply));
endmodule

bind cardclk_ctl cardclk_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .apply(apply), .pend(pend), .hold(hold),
  .busy(xfer_busy), .div_q(div_q), .live_en(live.en), .live_div(live.div),
  .irq(irq)
);

// File: tb/cardclk_ctl_test.sv
module cardclk_ctl_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] GO   = 32'h8000_0000;
  localparam logic [31:0] ONLY = 32'h0020_0000;
  localparam logic [31:0] HOLD = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        xfer_busy = 1'b0;
  logic        card_clk;

  int total = 0;
  int bad = 0;

  cardclk_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_busy(xfer_busy),
    .card_clk(card_clk)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] cfg_word(input int d, input bit en);
    return {15'd0, en, 8'd0, d[7:0]};
  endfunction

  function automatic int exp_half(input int d);
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_applied(output int cyc);
    logic [31:0] v;
    cyc = -1;
    for (int i = 0; i < 400; i++) begin
      rd_reg(2'd1, v);
      if (!v[31]) begin cyc = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_update(input int d, input bit en);
    int c;
    wr_reg(2'd0, cfg_word(d, en));
    wr_reg(2'd1, GO | ONLY);
    wait_applied(c);
    wr_reg(2'd2, 32'h3);
  endtask

  task automatic meas(output int hi, output int lo);
    int n;
    hi = 0; lo = 0; n = 0;
    while (card_clk !== 1'b0 && n < 600) begin @(negedge clk); n++; end
    while (card_clk !== 1'b1 && n < 600) begin @(negedge clk); n++; end
    while (card_clk === 1'b1 && n < 600) begin hi++; @(negedge clk); n++; end
    while (card_clk === 1'b0 && n < 600) begin lo++; @(negedge clk); n++; end
  endtask

  task automatic runt_check(input int d_old, input int d_new);
    int run, n;
    bit prev, ok;
    int c;
    do_update(d_old, 1'b1);
    wr_reg(2'd0, cfg_word(d_new, 1'b1));
    wr_reg(2'd1, GO | ONLY);
    while (card_clk !== 1'b0) @(negedge clk);
    ok = 1'b1; run = 0; prev = 1'b0; n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (card_clk) run++;
      else if (prev) begin
        if (run != d_old && run != d_new) begin ok = 1'b0; n = run; end
        run = 0;
      end
      prev = card_clk;
    end
    chk(ok, "R9 high pulse length", n, d_new);
    wait_applied(c);
    wr_reg(2'd2, 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi, lo, c, d, n1;
    bit en, ok;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], v);
      chk(v == 0, "R1 reset register", int'(v), 0);
    end
    chk(card_clk == 1'b0, "R1 reset card_clk", int'(card_clk), 0);

    // R2 staging does not touch live settings
    wr_reg(2'd0, cfg_word(3, 1'b1));
    rd_reg(2'd0, v);
    chk(v == cfg_word(3, 1'b1), "R2 staged readback", int'(v), int'(cfg_word(3, 1'b1)));
    repeat (10) @(negedge clk);
    rd_reg(2'd3, v);
    chk(v == 0, "R2 live unchanged", int'(v), 0);
    chk(card_clk == 1'b0, "R2 clock still off", int'(card_clk), 0);

    // R3 malformed commands ignored
    wr_reg(2'd1, GO);
    rd_reg(2'd1, v);
    chk(v[31] == 1'b0, "R3 start without update-only", int'(v[31]), 0);
    wr_reg(2'd1, ONLY);
    repeat (3) @(negedge clk);
    rd_reg(2'd3, v);
    chk(v == 0, "R3 update-only without start", int'(v), 0);

    // R3 valid update: start reads 1 then clears
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = GO | ONLY;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_reg(2'd1, v);
    chk(v[31] == 1'b1, "R3 start reads 1 while pending", int'(v[31]), 1);
    @(negedge clk);
    rd_reg(2'd1, v);
    chk(v[31] == 1'b0, "R3 start self-clears", int'(v[31]), 0);
    rd_reg(2'd3, v);
    chk(v == cfg_word(3, 1'b1), "R3 live loaded", int'(v), int'(cfg_word(3, 1'b1)));

    // R5 status bits and write-1-to-clear
    rd_reg(2'd2, v);
    chk(v[1:0] == 2'b11, "R5 both status bits set", int'(v[1:0]), 3);
    wr_reg(2'd2, 32'h0);
    rd_reg(2'd2, v);
    chk(v[1:0] == 2'b11, "R5 write 0 keeps bits", int'(v[1:0]), 3);
    wr_reg(2'd2, 32'h1);
    rd_reg(2'd2, v);
    chk(v[1:0] == 2'b10, "R5 clear bit 0 only", int'(v[1:0]), 2);
    wr_reg(2'd2, 32'h2);
    rd_reg(2'd2, v);
    chk(v[1:0] == 2'b00, "R5 clear bit 1", int'(v[1:0]), 0);

    // R6 directed divide by 3
    meas(hi, lo);
    chk(hi == exp_half(3) && lo == exp_half(3), "R6 divide 3 high", hi, exp_half(3));

    // R4 wait flag defers while busy; second request ignored (R3)
    wr_reg(2'd0, cfg_word(2, 1'b1));
    xfer_busy = 1'b1;
    wr_reg(2'd1, GO | ONLY | HOLD);
    wr_reg(2'd1, GO | ONLY);
    repeat (20) @(negedge clk);
    rd_reg(2'd1, v);
    chk(v[31] == 1'b1, "R4 deferred while busy", int'(v[31]), 1);
    chk(v[13] == 1'b1, "R3 pending request not overwritten", int'(v[13]), 1);
    rd_reg(2'd3, v);
    chk(v == cfg_word(3, 1'b1), "R4 live unchanged while busy", int'(v), int'(cfg_word(3, 1'b1)));
    xfer_busy = 1'b0;
    wait_applied(c);
    chk(c >= 0, "R4 applied after busy drops", c, 0);
    rd_reg(2'd3, v);
    chk(v == cfg_word(2, 1'b1), "R4 live after busy", int'(v), int'(cfg_word(2, 1'b1)));
    wr_reg(2'd2, 32'h3);

    // R4 busy ignored without wait flag
    wr_reg(2'd0, cfg_word(4, 1'b1));
    xfer_busy = 1'b1;
    wr_reg(2'd1, GO | ONLY);
    wait_applied(c);
    chk(c >= 0, "R4 no wait flag ignores busy", c, 0);
    xfer_busy = 1'b0;
    wr_reg(2'd2, 32'h3);

    // R9 runt-free changes both directions
    runt_check(4, 1);
    runt_check(1, 5);

    // R7 pass-through
    do_update(0, 1'b1);
    repeat (3) @(negedge clk);
    ok = 1'b1; n1 = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (card_clk !== 1'b1) ok = 1'b0;
      @(negedge clk); #1;
      if (card_clk !== 1'b0) ok = 1'b0;
      n1++;
    end
    chk(ok, "R7 follows module clock", int'(ok), 1);

    // R8 disabled holds low
    do_update(5, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (card_clk !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R8 held low when off", int'(ok), 1);

    // Random settings: R6, R7, R8
    for (int k = 0; k < 20; k++) begin
      d  = int'($urandom % 7);
      en = ($urandom % 4) != 0;
      do_update(d, en);
      repeat (2) @(negedge clk);
      if (!en) begin
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
          @(posedge clk); #1;
          if (card_clk !== 1'b0) ok = 1'b0;
        end
        chk(ok, "R8 random off", int'(ok), 1);
      end else if (d == 0) begin
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
          @(posedge clk); #1;
          if (card_clk !== 1'b1) ok = 1'b0;
          @(negedge clk); #1;
          if (card_clk !== 1'b0) ok = 1'b0;
        end
        chk(ok, "R7 random pass-through", int'(ok), 1);
      end else begin
        meas(hi, lo);
        chk(hi == exp_half(d), "R6 random high length", hi, exp_half(d));
        chk(lo == exp_half(d), "R6 random low length", lo, exp_half(d));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule